// File: doc/BRIEF.md
# Accumulator Rounding Unit with Tie-Mode Select

This block rounds a 40-bit multiply-accumulate result to its upper 24 bits. The value is an 8-bit guard byte, a 16-bit upper word and a 16-bit lower word. Rounding adds one half of the lower word's range and lets the carry ripple into the upper word and the guard byte. A mode input picks how an exact half is resolved. Biased mode always rounds the half up. Unbiased mode rounds to the nearest even upper word. Every other lower-word value rounds the same way in both modes.

A caller drives the value and the mode, then raises the round strobe for one cycle. The rounded value is registered and appears on the next clock edge with a valid flag. The lower word is passed through unchanged, so that the exact-half case can still be seen after rounding. The output register keeps its value until the next strobe.

Top module: `mac_round_unit`

## Requirements
- R1: While reset is held, and after it is released with no strobe, `accOut` is 0 and `accValid` is 0.
- R2: `accValid` is 1 in the cycle after a cycle with `roundEn` high, and 0 in the cycle after a cycle with `roundEn` low.
- R3: When the lower word `accIn[15:0]` is below 0x8000, the rounded upper 24 bits equal `accIn[39:16]` in both modes.
- R4: When the lower word is above 0x8000, the rounded upper 24 bits equal `accIn[39:16] + 1` in both modes.
- R5: When the lower word is exactly 0x8000 and `biasMode` is 1, the rounded upper 24 bits equal `accIn[39:16] + 1`.
- R6: When the lower word is exactly 0x8000 and `biasMode` is 0, the rounded upper 24 bits are `accIn[39:16] + 1` if bit 16 of the input is 1, and `accIn[39:16]` unchanged if bit 16 is 0. Either way, bit 16 of the result is 0.
- R7: `accOut[15:0]` equals the lower word that was sampled with the strobe.
- R8: The carry runs through the guard byte, and the 40-bit result wraps modulo 2^40.
- R9: In a cycle with `roundEn` low, `accOut` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| roundEn | input | 1 | Round strobe; samples `accIn` and `biasMode` |
| biasMode | input | 1 | 1 = round exact halves up, 0 = round exact halves to even |
| accIn | input | 40 | Accumulator value: guard[39:32], upper[31:16], lower[15:0] |
| accOut | output | 40 | Rounded value: upper 24 bits rounded, lower word kept |
| accValid | output | 1 | High one cycle after the strobe |

## Verification
The value is tried with lower words 0x7FFF, 0x8000 and 0x8001. Each one is run with an even and an odd upper word and in both modes. This separates the single tie case, where the mode matters, from its two neighbours, where it must not matter. Further vectors use a general lower word, a carry out of the upper word into the guard byte, and a wrap of all 40 bits. Directed tests cover strobes on consecutive cycles and changes on the input while no strobe is given.

// File: rtl/mac_round_pkg.sv
package mac_round_pkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic capture;    // load the output register this cycle
    logic forceEven;  // clear the upper-word LSB of the rounded sum
  } rnd_strobe_t;
endpackage

// File: rtl/mac_round_ctrl.sv
module mac_round_ctrl
  import mac_round_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        roundEn,
  input  logic        biasMode,
  input  logic        isTie,
  output rnd_strobe_t strobe,
  output logic        accValid
);
  always_comb begin
    strobe.capture   = roundEn;
    strobe.forceEven = roundEn && !biasMode && isTie;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accValid <= 1'b0;
    else       accValid <= roundEn;
  end
endmodule

// File: rtl/mac_round_datapath.sv
module mac_round_datapath
  import mac_round_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int WORD_W  = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  rnd_strobe_t                     strobe,
  input  logic [GUARD_W+2*WORD_W-1:0]     accIn,
  output logic                            isTie,
  output logic [GUARD_W+2*WORD_W-1:0]     accOut
);
  localparam int ACC_W = GUARD_W + 2*WORD_W;
  localparam int UP_W  = GUARD_W + WORD_W;
  localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] lowWord;
  logic [UP_W-1:0]   upperIn;
  logic [UP_W-1:0]   upperSum;
  logic [UP_W-1:0]   upperRnd;

  assign lowWord = accIn[WORD_W-1:0];
  assign upperIn = accIn[ACC_W-1:WORD_W];
  assign isTie   = (lowWord == HALF);

  // Adding one half carries into the upper part exactly when the low MSB is set
  assign upperSum = upperIn + {{(UP_W-1){1'b0}}, lowWord[WORD_W-1]};

  always_comb begin
    upperRnd = upperSum;
    if (strobe.forceEven) upperRnd[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               accOut <= '0;
    else if (strobe.capture) accOut <= {upperRnd, lowWord};
  end
endmodule

// File: rtl/mac_round_unit.sv
module mac_round_unit
  import mac_round_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int WORD_W  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        roundEn,
  input  logic                        biasMode,
  input  logic [GUARD_W+2*WORD_W-1:0] accIn,
  output logic [GUARD_W+2*WORD_W-1:0] accOut,
  output logic                        accValid
);
  rnd_strobe_t strobe;
  logic        isTie;

  mac_round_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .roundEn  (roundEn),
    .biasMode (biasMode),
    .isTie    (isTie),
    .strobe   (strobe),
    .accValid (accValid)
  );

  mac_round_datapath #(.GUARD_W(GUARD_W), .WORD_W(WORD_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .accIn  (accIn),
    .isTie  (isTie),
    .accOut (accOut)
  );
endmodule

// File: rtl/mac_round_checker.sv
module mac_round_checker #(
  parameter int GUARD_W = 8,
  parameter int WORD_W  = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        roundEn,
  input logic                        biasMode,
  input logic [GUARD_W+2*WORD_W-1:0] accIn,
  input logic [GUARD_W+2*WORD_W-1:0] accOut,
  input logic                        accValid
);
  localparam int ACC_W = GUARD_W + 2*WORD_W;
  localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    roundEn |=> accValid); // R2
  AST_NO_VALID_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !roundEn |=> !accValid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !roundEn |=> $stable(accOut)); // R9
  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    roundEn |=> accOut[WORD_W-1:0] == $past(accIn[WORD_W-1:0])); // R7
  AST_BELOW_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (roundEn && !accIn[WORD_W-1]) |=> accOut[ACC_W-1:WORD_W] == $past(accIn[ACC_W-1:WORD_W])); // R3
  AST_TIE_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (roundEn && !biasMode && accIn[WORD_W-1:0] == HALF) |=> !accOut[WORD_W]); // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |-> (accOut == '0 && !accValid)); // R1
endmodule

bind mac_round_unit mac_round_checker #(.GUARD_W(GUARD_W), .WORD_W(WORD_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .roundEn  (roundEn),
  .biasMode (biasMode),
  .accIn    (accIn),
  .accOut   (accOut),
  .accValid (accValid)
);

// File: tb/test_mac_round_unit.sv
module test_mac_round_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        roundEn = 1'b0;
  logic        biasMode = 1'b0;
  logic [39:0] accIn = '0;
  logic [39:0] accOut;
  logic        accValid;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mac_round_unit i_mac_round_unit (
    .clk(clk), .rstN(rstN), .roundEn(roundEn), .biasMode(biasMode),
    .accIn(accIn), .accOut(accOut), .accValid(accValid)
  );

  // {mode, input, expected, requirement number}
  localparam int NV = 13;
  localparam logic [88:0] VEC [NV] = '{
    {1'b1, 40'h00_0000_8000, 40'h00_0001_8000, 8'd5},  // R5 even tie, biased
    {1'b1, 40'h00_0001_8000, 40'h00_0002_8000, 8'd5},  // R5 odd tie, biased
    {1'b0, 40'h00_0000_8000, 40'h00_0000_8000, 8'd6},  // R6 even tie stays
    {1'b0, 40'h00_0001_8000, 40'h00_0002_8000, 8'd6},  // R6 odd tie goes up
    {1'b0, 40'h00_0000_8001, 40'h00_0001_8001, 8'd4},  // R4 above half, unbiased
    {1'b1, 40'h00_0001_8001, 40'h00_0002_8001, 8'd4},  // R4 above half, biased
    {1'b1, 40'h00_0000_7FFF, 40'h00_0000_7FFF, 8'd3},  // R3 below half, biased
    {1'b0, 40'h00_0001_7FFF, 40'h00_0001_7FFF, 8'd3},  // R3 below half, unbiased
    {1'b0, 40'h12_3456_ABCD, 40'h12_3457_ABCD, 8'd4},  // R4 general value, R7 low kept
    {1'b1, 40'h00_FFFF_8000, 40'h01_0000_8000, 8'd8},  // R8 carry into guard byte
    {1'b0, 40'hFF_FFFF_8000, 40'h00_0000_8000, 8'd8},  // R8 wrap at 2^40
    {1'b0, 40'h7F_FFFE_8000, 40'h7F_FFFE_8000, 8'd6},  // R6 large even tie
    {1'b1, 40'h7F_FFFF_C000, 40'h80_0000_C000, 8'd8}   // R8 carry to guard MSB
  };

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(accOut == 40'h0, "R1 reset out", accOut, 40'h0);
    check(accValid == 1'b0, "R1 reset valid", {39'h0, accValid}, 40'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(accOut == 40'h0 && !accValid, "R1 after release", accOut, 40'h0);

    for (int i = 0; i < NV; i++) begin
      biasMode = VEC[i][88];
      accIn    = VEC[i][87:48];
      roundEn  = 1'b1;
      @(negedge clk);
      roundEn  = 1'b0;
      check(accValid == 1'b1, $sformatf("R2 valid vec %0d", i), {39'h0, accValid}, 40'h1);
      check(accOut == VEC[i][47:8], $sformatf("R%0d vec %0d", VEC[i][7:0], i), accOut, VEC[i][47:8]);
      @(negedge clk);
      check(accValid == 1'b0, $sformatf("R2 valid drop vec %0d", i), {39'h0, accValid}, 40'h0);
    end

    // R9: input and mode changes without a strobe leave the output alone
    accIn = 40'h55_AAAA_F000; biasMode = 1'b1;
    @(negedge clk);
    check(accOut == 40'h80_0000_C000, "R9 hold", accOut, 40'h80_0000_C000);

    // R2/R7: strobes on consecutive cycles
    biasMode = 1'b0; accIn = 40'h00_0003_8000; roundEn = 1'b1;
    @(negedge clk);
    check(accOut == 40'h00_0004_8000 && accValid, "R6 back-to-back 1", accOut, 40'h00_0004_8000);
    accIn = 40'h00_0004_1234;
    @(negedge clk);
    roundEn = 1'b0;
    check(accOut == 40'h00_0004_1234 && accValid, "R7 back-to-back 2", accOut, 40'h00_0004_1234);

    // R1: reset in the middle of operation clears the output
    rstN = 1'b0;
    @(negedge clk);
    check(accOut == 40'h0 && !accValid, "R1 re-reset", accOut, 40'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule